// File: doc/BRIEF.md
# Three-Phase Sinusoidal PWM Generator

This block drives three pulse-width-modulated outputs whose duty cycles follow sine waves spaced a third of a turn apart, one per phase of a three-phase load. A single 256-entry table of 8-bit duty codes describes one full sine cycle. All three phases read that one table, each at its own fixed index offset from a shared base index, so only one copy of the table is stored.

A free-running 8-bit carrier counter sets the PWM period at 256 clock cycles. Each phase output is high while the carrier is below that phase's duty code. New duty codes are taken from the table only when the carrier rolls over, so every PWM period uses a single, complete code. A programmable step period sets how often the base index moves one entry forward. That step rate alone sets the frequency of the synthesized sine. Lowering the enable input parks the block: the index and both counters clear, and the outputs go low.

Top module: `spwm3_gen`

## Requirements
- R1: Table entry k holds 127*sin(2*pi*k/256)+128 rounded to the nearest integer; in particular entries 0, 1, 2, 254 and 255 hold 128, 131, 134, 122 and 125.
- R2: The phase R duty code is taken from table entry k, where k is the base index.
- R3: The phase Y duty code is taken from entry (k+85) mod 256, and the phase B duty code from entry (k+171) mod 256.
- R4: While enabled, a step counter increments each clock. At each edge where its count is greater than or equal to the period input, it clears and the base index k advances by one, wrapping from 255 to 0. A constant period P therefore advances k once every P+1 enabled cycles.
- R5: While enabled, the carrier counts 0 to 255 and wraps, one step per clock. Each phase output is high exactly when the carrier is strictly less than that phase's current duty output.
- R6: Duty outputs change only at the clock edge where the carrier goes from 255 to 0. At that edge they load the table entries addressed by the base index as it stood before the edge.
- R7: While reset is high or enable is low, k, the step count and the carrier are 0. All three PWM outputs are low. The duty outputs hold entries 0, 85 and 171 (128 for phase R).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the block |
| period | input | 16 | Base-index step period, in clocks minus one |
| pwm_r | output | 1 | Phase R PWM output |
| pwm_y | output | 1 | Phase Y PWM output |
| pwm_b | output | 1 | Phase B PWM output |
| duty_r | output | 8 | Phase R duty code in use |
| duty_y | output | 8 | Phase Y duty code in use |
| duty_b | output | 8 | Phase B duty code in use |

## Verification
The bench targets the rollover boundary. A design that latched duty codes mid-period would show a changed duty value while the carrier is nonzero. A design that latched one cycle late, or used the index after its increment, would load the neighbouring table entry at the first wrap after enabling with a period of 0 (125 is expected there). Step periods of 0, 255 and large values check the `>=` wrap rule and the P+1 spacing. Toggling enable and reset mid-cycle exposes a design that failed to clear the counters or to reload the idle duty codes, because the first period after restart would then start from the wrong entry. The bench also checks the carrier compare at codes near the extremes: the output must be high at carrier 0 and low at carrier 255.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int IDX_W  = 8;
    localparam int DUTY_W = 8;
    localparam int NPH    = 3;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int MID    = 1 << (DUTY_W - 1);
    localparam int AMPL   = MID - 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DUTY_W-1:0] duty_t;

    typedef enum logic [1:0] {
        PH_R = 2'd0,
        PH_Y = 2'd1,
        PH_B = 2'd2
    } phase_e;

    typedef struct packed {
        logic  run;
        logic  wrap;
        duty_t car;
        idx_t  k;
    } timebase_t;

    // Offset of phase p: p thirds of the table, rounded to nearest entry.
    function automatic idx_t phase_offset(input int p);
        return idx_t'((2 * DEPTH * p + NPH) / (2 * NPH));
    endfunction

    // Duty code for table entry k of one full sine cycle.
    function automatic duty_t sine_duty(input int k);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979323846 * $itor(k) / $itor(DEPTH);
        val = $itor(AMPL) * $sin(ang) + $itor(MID);
        return duty_t'($rtoi(val + 0.5));
    endfunction

endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom
    import spwm_pkg::*;
#(
    parameter int NRD = 3
) (
    input  idx_t  rd_addr [NRD],
    output duty_t rd_data [NRD]
);

    duty_t tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tbl[i] = sine_duty(i);
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = tbl[rd_addr[r]];
    end

endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase
    import spwm_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output timebase_t        tb_o
);

    logic [PER_W-1:0] cnt_q;
    idx_t             k_q;
    duty_t            car_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            k_q   <= '0;
            car_q <= '0;
        end else begin
            car_q <= car_q + 1'b1;
            if (cnt_q >= period) begin
                cnt_q <= '0;
                k_q   <= k_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tb_o.run  = en && !rst;
    assign tb_o.wrap = (car_q == '1);
    assign tb_o.car  = car_q;
    assign tb_o.k    = k_q;

    p_index_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q >= period) ##1 en |-> (k_q == idx_t'($past(k_q) + 1'b1)));

    p_carrier_step_r5: assert property (@(posedge clk) disable iff (rst)
        en ##1 en |-> (car_q == duty_t'($past(car_q) + 1'b1)));

    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (k_q == '0 && car_q == '0 && cnt_q == '0));

endmodule

// File: rtl/spwm_phase_ch.sv
module spwm_phase_ch
    import spwm_pkg::*;
#(
    parameter idx_t OFFSET = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  timebase_t tb_i,
    output idx_t      rd_addr,
    input  duty_t     rd_data,
    output duty_t     duty_o,
    output logic      pwm_o
);

    localparam duty_t IDLE_DUTY = sine_duty(int'(OFFSET));

    duty_t duty_q;

    assign rd_addr = idx_t'(tb_i.k + OFFSET);

    always_ff @(posedge clk) begin
        if (rst || !tb_i.run) begin
            duty_q <= IDLE_DUTY;
        end else if (tb_i.wrap) begin
            duty_q <= rd_data;
        end
    end

    assign duty_o = duty_q;
    assign pwm_o  = tb_i.run && (tb_i.car < duty_q);

    p_duty_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tb_i.run && !tb_i.wrap) ##1 tb_i.run |-> $stable(duty_q));

    p_start_high_r5: assert property (@(posedge clk) disable iff (rst)
        (tb_i.run && tb_i.car == '0) |-> pwm_o);

    p_end_low_r5: assert property (@(posedge clk) disable iff (rst)
        (tb_i.car == '1) |-> !pwm_o);

endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen
    import spwm_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             pwm_r,
    output logic             pwm_y,
    output logic             pwm_b,
    output logic [7:0]       duty_r,
    output logic [7:0]       duty_y,
    output logic [7:0]       duty_b
);

    timebase_t        tb;
    idx_t             rd_addr [NPH];
    duty_t            rd_data [NPH];
    duty_t            duty_w  [NPH];
    logic [NPH-1:0]   pwm_w;

    spwm_timebase #(.PER_W(PER_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .period (period),
        .tb_o   (tb)
    );

    spwm_sine_rom #(.NRD(NPH)) u_rom (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        spwm_phase_ch #(.OFFSET(phase_offset(p))) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tb_i    (tb),
            .rd_addr (rd_addr[p]),
            .rd_data (rd_data[p]),
            .duty_o  (duty_w[p]),
            .pwm_o   (pwm_w[p])
        );
    end

    assign pwm_r  = pwm_w[PH_R];
    assign pwm_y  = pwm_w[PH_Y];
    assign pwm_b  = pwm_w[PH_B];
    assign duty_r = duty_w[PH_R];
    assign duty_y = duty_w[PH_Y];
    assign duty_b = duty_w[PH_B];

endmodule

// File: tb/spwm3_gen_bench.sv
module spwm3_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] period = 16'd0;
    logic        pwm_r, pwm_y, pwm_b;
    logic [7:0]  duty_r, duty_y, duty_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spwm3_gen u_spwm3_gen (
        .clk(clk), .rst(rst), .en(en), .period(period),
        .pwm_r(pwm_r), .pwm_y(pwm_y), .pwm_b(pwm_b),
        .duty_r(duty_r), .duty_y(duty_y), .duty_b(duty_b)
    );

    function automatic int tbl(input int k);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979 * k / 256.0) + 128.0;
        return int'(x);
    endfunction

    function automatic int offs(input int p);
        return (p == 0) ? 0 : (p == 1) ? 85 : 171;
    endfunction

    // Reference model, advanced on each rising edge.
    int m_cnt = 0, m_k = 0, m_car = 0;
    int m_duty [3];
    int prev_duty [3];

    always @(posedge clk) begin
        if (rst || !en) begin
            m_cnt = 0; m_k = 0; m_car = 0;
            for (int p = 0; p < 3; p++) m_duty[p] = tbl(offs(p));
        end else begin
            if (m_car == 255)
                for (int p = 0; p < 3; p++) m_duty[p] = tbl((m_k + offs(p)) % 256);
            m_car = (m_car + 1) % 256;
            if (m_cnt >= int'(period)) begin
                m_cnt = 0;
                m_k = (m_k + 1) % 256;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int dv [3];
        int pv [3];
        bit run;
        dv[0] = int'(duty_r); dv[1] = int'(duty_y); dv[2] = int'(duty_b);
        pv[0] = int'(pwm_r);  pv[1] = int'(pwm_y);  pv[2] = int'(pwm_b);
        run = en && !rst;
        chk(dv[0] == m_duty[0], "R2 duty_r", dv[0], m_duty[0]);
        chk(dv[1] == m_duty[1], "R3 duty_y", dv[1], m_duty[1]);
        chk(dv[2] == m_duty[2], "R3 duty_b", dv[2], m_duty[2]);
        for (int p = 0; p < 3; p++) begin
            int e;
            e = (run && (m_car < m_duty[p])) ? 1 : 0;
            if (!run) chk(pv[p] == 0, "R7 pwm idle", pv[p], 0);
            else      chk(pv[p] == e, "R5 pwm compare", pv[p], e);
            if (run && m_car != 0)
                chk(dv[p] == prev_duty[p], "R6 duty hold", dv[p], prev_duty[p]);
            prev_duty[p] = dv[p];
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed_2024);
        for (int p = 0; p < 3; p++) prev_duty[p] = 0;

        // Reset state
        run_cycles(3);
        chk(duty_r == 8'd128, "R7 reset duty_r", int'(duty_r), 128);
        chk(duty_y == 8'(tbl(85)), "R7 reset duty_y", int'(duty_y), tbl(85));
        chk({pwm_r, pwm_y, pwm_b} == 3'b000, "R7 reset pwm", int'({pwm_r, pwm_y, pwm_b}), 0);

        // Period 255: k advances every 256 cycles; wraps load entries 0, 1, 2
        rst = 1'b0; en = 1'b1; period = 16'd255;
        run_cycles(512);
        chk(duty_r == 8'd131, "R1 R4 entry 1", int'(duty_r), 131);
        run_cycles(256);
        chk(duty_r == 8'd134, "R1 R4 entry 2", int'(duty_r), 134);

        // Enable low parks the block
        en = 1'b0;
        run_cycles(5);
        chk(duty_r == 8'd128, "R7 idle duty_r", int'(duty_r), 128);
        chk(pwm_r == 1'b0, "R7 idle pwm_r", int'(pwm_r), 0);

        // Period 0: first wrap uses k = 255
        en = 1'b1; period = 16'd0;
        run_cycles(256);
        chk(duty_r == 8'd125, "R1 R4 entry 255", int'(duty_r), 125);
        chk(duty_y == 8'(tbl(84)), "R3 Y wrap", int'(duty_y), tbl(84));
        chk(duty_b == 8'(tbl(170)), "R3 B wrap", int'(duty_b), tbl(170));

        // Constrained random runs
        for (int it = 0; it < 100; it++) begin
            int sel;
            sel = int'($urandom % 8);
            if (sel < 6)       period = 16'($urandom % 4);
            else if (sel == 6) period = 16'd255;
            else               period = 16'($urandom % 2000);
            if ($urandom % 10 == 0) begin
                en = 1'b0;
                run_cycles(int'($urandom % 5) + 1);
                en = 1'b1;
            end
            if ($urandom % 40 == 0) begin
                rst = 1'b1;
                run_cycles(2);
                rst = 1'b0;
            end
            run_cycles(int'($urandom % 1200) + 100);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule